// File: doc/BRIEF.md
# Four-Lane Demultiplexing Write Path

This block takes one narrow data word on its input side and spreads it over four output lanes of the same width. Every lane owns a storage cell that can be used two ways: as a transparent latch, where the lane follows the input while its latch enable is high, or as an edge-triggered register that loads on the shared clock when its clock enable is active. A single active-low clock enable is shared by all lanes. A 2-bit selector steers it to exactly one lane, so a sequence of cycles can fill the lanes one at a time from the same input.

Each lane's output carries a valid flag instead of a high-impedance state. The flag is raised only when a global output enable and that lane's own output enable are both low. While a lane is not valid, its data field reads as zero. Transparency is modelled on the system clock: a lane whose latch enable is high shows the live input at once and also rewrites its stored value on every clock edge. When the latch enable drops, the lane keeps the input word it stored at the last rising edge.

Top module: `quad_lane_demux`

## Requirements
- R1: A synchronous active-high reset clears every lane's stored value to zero. After reset, with latch enables low and outputs enabled, every lane reads 0.
- R2: While a lane's latch enable is high, its data output equals the live input in the same cycle, whatever the clock enable and selector are doing.
- R3: After a lane's latch enable goes low, the lane holds the input value sampled at the last rising clock edge at which the latch enable was high.
- R4: With its latch enable low, a lane whose effective clock enable is low loads the input at the rising clock edge. The new value shows from that edge on.
- R5: When the shared active-low clock enable is high, no lane with a low latch enable changes its stored value.
- R6: The selector routes the clock enable to one lane only: value 0 to lane 0 (bits 3:0 of the data output), 1 to lane 1 (bits 7:4), 2 to lane 2 (bits 11:8) and 3 to lane 3 (bits 15:12). Unselected lanes hold their value.
- R7: A lane's valid flag (bit k of the valid output for lane k) is 1 exactly when the global output enable and that lane's output enable are both low.
- R8: A lane whose valid flag is 0 presents all-zero data. Its stored value is not lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | DW | Input data word |
| lat_en | input | LANES | Per-lane latch enable, active high |
| clk_en_n | input | 1 | Shared clock enable, active low |
| ce_sel | input | SELW | Selects the lane that receives the clock enable |
| oe_all_n | input | 1 | Global output enable, active low |
| oe_lane_n | input | LANES | Per-lane output enable, active low |
| b_data | output | LANES*DW | Lane data, lane k in bits k*DW +: DW |
| b_vld | output | LANES | Per-lane valid flag |

## Verification
A wrong stored value is invisible while a lane is transparent or disabled. It only appears once the latch enable is low and both output enables are low, and from then on it stays on that lane's data field at every cycle. Misrouting in the selector shows as a lane that changes in the cycle after the capture edge when it should not, or one that keeps its old value. The comparison therefore checks the full data bus once per cycle, so a wrong lane is caught one cycle after the faulty edge. Capture and hold are also checked against the stored state every clock, so they do not depend on the output enables.

// File: rtl/quad_lane_demux_pkg.sv
package quad_lane_demux_pkg;
  localparam int DEF_DW    = 4;
  localparam int DEF_LANES = 4;

  typedef struct packed {
    logic le;
    logic ce_n;
  } lane_ctl_t;
endpackage

// File: rtl/qld_ce_decoder.sv
module qld_ce_decoder #(
  parameter int LANES = 4,
  localparam int SELW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             ce_n,
  input  logic [SELW-1:0]  sel,
  output logic [LANES-1:0] lane_ce_n
);
  for (genvar k = 0; k < LANES; k++) begin : g_dec
    always_comb lane_ce_n[k] = ce_n | (sel != SELW'(k));
  end
endmodule

// File: rtl/qld_lane_cell.sv
module qld_lane_cell
  import quad_lane_demux_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  lane_ctl_t     ctl,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic [DW-1:0] vis
);
  always_ff @(posedge clk) begin
    if (rst)            q <= '0;
    else if (ctl.le)    q <= d;
    else if (!ctl.ce_n) q <= d;
  end

  always_comb vis = ctl.le ? d : q;
endmodule

// File: rtl/qld_out_qual.sv
module qld_out_qual #(
  parameter int DW = 4
) (
  input  logic          oe_all_n,
  input  logic          oe_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          vld
);
  always_comb begin
    vld  = ~(oe_all_n | oe_n);
    dout = vld ? din : '0;
  end
endmodule

// File: rtl/quad_lane_demux.sv
module quad_lane_demux
  import quad_lane_demux_pkg::*;
#(
  parameter int DW    = DEF_DW,
  parameter int LANES = DEF_LANES,
  localparam int SELW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DW-1:0]       a_in,
  input  logic [LANES-1:0]    lat_en,
  input  logic                clk_en_n,
  input  logic [SELW-1:0]     ce_sel,
  input  logic                oe_all_n,
  input  logic [LANES-1:0]    oe_lane_n,
  output logic [LANES*DW-1:0] b_data,
  output logic [LANES-1:0]    b_vld
);
  logic [LANES-1:0]    lane_ce_n;
  logic [LANES*DW-1:0] lane_q;
  logic [LANES*DW-1:0] lane_vis;

  qld_ce_decoder #(.LANES(LANES)) u_dec (
    .ce_n      (clk_en_n),
    .sel       (ce_sel),
    .lane_ce_n (lane_ce_n)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lane_ctl_t ctl;
    always_comb begin
      ctl.le   = lat_en[k];
      ctl.ce_n = lane_ce_n[k];
    end

    qld_lane_cell #(.DW(DW)) u_cell (
      .clk (clk),
      .rst (rst),
      .ctl (ctl),
      .d   (a_in),
      .q   (lane_q[k*DW +: DW]),
      .vis (lane_vis[k*DW +: DW])
    );

    qld_out_qual #(.DW(DW)) u_oq (
      .oe_all_n (oe_all_n),
      .oe_n     (oe_lane_n[k]),
      .din      (lane_vis[k*DW +: DW]),
      .dout     (b_data[k*DW +: DW]),
      .vld      (b_vld[k])
    );
  end
endmodule

// File: rtl/quad_lane_demux_chk.sv
module quad_lane_demux_chk #(
  parameter int DW    = 4,
  parameter int LANES = 4,
  localparam int SELW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic [DW-1:0]       a_in,
  input logic [LANES-1:0]    lat_en,
  input logic                clk_en_n,
  input logic [SELW-1:0]     ce_sel,
  input logic                oe_all_n,
  input logic [LANES-1:0]    oe_lane_n,
  input logic [LANES*DW-1:0] b_data,
  input logic [LANES-1:0]    b_vld,
  input logic [LANES*DW-1:0] lane_q
);
  for (genvar k = 0; k < LANES; k++) begin : g_chk
    // R1
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> (lane_q[k*DW +: DW] == '0));

    // R2
    transparent_load_chk: assert property (@(posedge clk) disable iff (rst)
      lat_en[k] |=> (lane_q[k*DW +: DW] == $past(a_in)));

    // R4
    edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (!lat_en[k] && !clk_en_n && ce_sel == SELW'(k)) |=> (lane_q[k*DW +: DW] == $past(a_in)));

    // R5
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
      (!lat_en[k] && clk_en_n) |=> $stable(lane_q[k*DW +: DW]));

    // R6
    unselected_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!lat_en[k] && ce_sel != SELW'(k)) |=> $stable(lane_q[k*DW +: DW]));

    // R7
    valid_needs_enables_chk: assert property (@(posedge clk) disable iff (rst)
      b_vld[k] |-> (!oe_all_n && !oe_lane_n[k]));

    // R8
    invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !b_vld[k] |-> (b_data[k*DW +: DW] == '0));
  end
endmodule

bind quad_lane_demux quad_lane_demux_chk #(.DW(DW), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .a_in      (a_in),
  .lat_en    (lat_en),
  .clk_en_n  (clk_en_n),
  .ce_sel    (ce_sel),
  .oe_all_n  (oe_all_n),
  .oe_lane_n (oe_lane_n),
  .b_data    (b_data),
  .b_vld     (b_vld),
  .lane_q    (lane_q)
);

// File: tb/test_quad_lane_demux.sv
module test_quad_lane_demux;
  localparam int PER   = 10;
  localparam int DW    = 4;
  localparam int LANES = 4;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [DW-1:0]       a_in = '0;
  logic [LANES-1:0]    lat_en = '0;
  logic                clk_en_n = 1'b1;
  logic [1:0]          ce_sel = '0;
  logic                oe_all_n = 1'b0;
  logic [LANES-1:0]    oe_lane_n = '0;
  logic [LANES*DW-1:0] b_data;
  logic [LANES-1:0]    b_vld;

  typedef struct {
    logic [LANES*DW-1:0] d;
    logic [LANES-1:0]    v;
    string               tag;
  } item_t;

  item_t sb[$];
  logic [DW-1:0] m_q [LANES];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(PER/2) clk = ~clk;

  quad_lane_demux #(.DW(DW), .LANES(LANES)) i_quad_lane_demux (
    .clk(clk), .rst(rst), .a_in(a_in), .lat_en(lat_en), .clk_en_n(clk_en_n),
    .ce_sel(ce_sel), .oe_all_n(oe_all_n), .oe_lane_n(oe_lane_n),
    .b_data(b_data), .b_vld(b_vld)
  );

  task automatic cyc(input string tag, input logic r, input logic [DW-1:0] a,
                     input logic [LANES-1:0] le, input logic cen, input logic [1:0] sel,
                     input logic oa, input logic [LANES-1:0] ol);
    item_t it;
    @(posedge clk);
    for (int k = 0; k < LANES; k++) begin
      if (rst) m_q[k] = '0;
      else if (lat_en[k]) m_q[k] = a_in;
      else if (!clk_en_n && ce_sel == 2'(k)) m_q[k] = a_in;
    end
    @(negedge clk);
    rst = r; a_in = a; lat_en = le; clk_en_n = cen; ce_sel = sel;
    oe_all_n = oa; oe_lane_n = ol;
    if (tag != "") begin
      for (int k = 0; k < LANES; k++) begin
        it.v[k] = !oa && !ol[k];
        it.d[k*DW +: DW] = it.v[k] ? (le[k] ? a : m_q[k]) : '0;
      end
      it.tag = tag;
      sb.push_back(it);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        it = sb.pop_front();
        total++;
        if (b_data !== it.d || b_vld !== it.v) begin
          bad++;
          $display("FAIL %s data=%h exp=%h vld=%b exp=%b", it.tag, b_data, it.d, b_vld, it.v);
        end
      end
    end
  end

  initial begin : watchdog
    #(PER * 100000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    cyc("", 1'b1, 4'h9, 4'b0000, 1'b1, 2'd0, 1'b0, 4'b0000);
    cyc("", 1'b1, 4'h9, 4'b0000, 1'b1, 2'd0, 1'b0, 4'b0000);
    // R1: reset leaves zeros
    cyc("R1", 1'b0, 4'h9, 4'b0000, 1'b1, 2'd0, 1'b0, 4'b0000);
    cyc("R1", 1'b0, 4'h7, 4'b0000, 1'b1, 2'd1, 1'b0, 4'b0000);
    // R2: transparent lanes follow input, clock enable ignored
    cyc("R2", 1'b0, 4'h5, 4'b1111, 1'b0, 2'd2, 1'b0, 4'b0000);
    cyc("R2", 1'b0, 4'hA, 4'b1111, 1'b1, 2'd0, 1'b0, 4'b0000);
    cyc("R2", 1'b0, 4'hC, 4'b0101, 1'b0, 2'd1, 1'b0, 4'b0000);
    // R3: latch enable low keeps last sampled value
    cyc("R3", 1'b0, 4'h3, 4'b0000, 1'b1, 2'd0, 1'b0, 4'b0000);
    cyc("R3", 1'b0, 4'hE, 4'b0000, 1'b1, 2'd0, 1'b0, 4'b0000);
    // R4, R6: load each lane in turn through the selector
    for (int s = 0; s < LANES; s++) begin
      cyc("R4", 1'b0, 4'(s + 6), 4'b0000, 1'b0, 2'(s), 1'b0, 4'b0000);
      cyc("R6", 1'b0, 4'hF, 4'b0000, 1'b1, 2'(s), 1'b0, 4'b0000);
    end
    // R5: clock enable off, nothing moves
    cyc("R5", 1'b0, 4'h1, 4'b0000, 1'b1, 2'd3, 1'b0, 4'b0000);
    cyc("R5", 1'b0, 4'h2, 4'b0000, 1'b1, 2'd1, 1'b0, 4'b0000);
    // R7, R8: output qualification
    cyc("R7", 1'b0, 4'h4, 4'b0000, 1'b1, 2'd0, 1'b1, 4'b0000);
    cyc("R8", 1'b0, 4'h4, 4'b0010, 1'b1, 2'd0, 1'b1, 4'b0000);
    cyc("R7", 1'b0, 4'h4, 4'b0000, 1'b1, 2'd0, 1'b0, 4'b0101);
    cyc("R8", 1'b0, 4'h4, 4'b0000, 1'b1, 2'd0, 1'b0, 4'b0000);
    // R6: mixed random traffic
    for (int i = 0; i < 60; i++) begin
      cyc("R6", 1'b0, 4'($urandom), 4'($urandom) & 4'($urandom), 1'($urandom),
          2'($urandom), ($urandom % 4) == 0, 4'($urandom) & 4'($urandom));
    end
    // R1: reset mid-run clears all lanes
    cyc("", 1'b1, 4'hB, 4'b0000, 1'b0, 2'd2, 1'b0, 4'b0000);
    cyc("R1", 1'b0, 4'hB, 4'b0000, 1'b1, 2'd2, 1'b0, 4'b0000);
    cyc("R1", 1'b0, 4'hB, 4'b0000, 1'b1, 2'd2, 1'b0, 4'b0000);
    repeat (3) @(negedge clk);
    #4;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule